// File: doc/BRIEF.md
# Gated Frequency and Period Counter

This block measures an external signal against a reference clock assumed to run at 7.2 MHz. In frequency mode it counts rising edges of either a high-band input or a low-band input during a fixed gate window. The high-band input first passes through a divide-by-8 prescaler, so the stored value is one eighth of its edge count. In period mode it instead counts cycles of a 900 kHz check tick, taken as every eighth reference cycle, across one or two full periods of the low-band input. The result is a reciprocal measurement that suits slow signals.

A controller sets the select, mode and gate-length inputs and raises the enable. When the `done_o` flag rises, the controller reads `count_o`. Lowering the enable clears the result and arms the block for the next run. The measured input passes through a two-flop synchroniser and an edge detector before it is used. The configuration is captured when a run starts.

The control sequence has five states. IDLE is held while the enable is low. IDLE goes to GATE when a frequency measurement is selected, and to ARM when a period measurement is selected. GATE goes to DONE when the window expires. ARM goes to SPAN on the first rising edge of the input. SPAN goes to DONE on the rising edge that completes the last required period. DONE holds until the enable falls. From every state, a low enable returns the block to IDLE.

Top module: `meas_counter`

## Requirements
- R1: While `meas_en` is 0, `count_o` is 0 and `done_o` is 0 one cycle later. Input edges that arrive while the block is disabled are never counted.
- R2: With `sel_hi`=1, a frequency run stores floor(E/HB_DIV) in `count_o`, where E is the number of `hi_in` rising edges inside the window. The default HB_DIV is 8.
- R3: With `sel_hi`=0 and `freq_sel`=1, a frequency run stores the number of `lo_in` rising edges inside the window. With `sel_hi`=1, `freq_sel` has no effect and the run is always a frequency run.
- R4: `done_o` rises exactly GATE_SHORT cycles (when `long_gate`=0) or GATE_LONG cycles (when `long_gate`=1) after the first clock edge that samples `meas_en`=1. The defaults are 432000 and 864000.
- R5: With `sel_hi`=0 and `freq_sel`=0, a period run stores floor(k·P/CHK_DIV). Here P is the `lo_in` period in reference cycles, k is 1 when `long_gate`=0 and 2 when `long_gate`=1, and the default CHK_DIV is 8.
- R6: `done_o` is 0 from the start of a run until it completes. After completion, `done_o` stays 1 and `count_o` stays unchanged for as long as `meas_en` remains 1, even if further input edges arrive.
- R7: `count_o` saturates at all ones (2^CNT_W−1) and never wraps.
- R8: `sel_hi`, `freq_sel` and `long_gate` are sampled only while the block is in IDLE. Changing them during a run does not affect that run's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (7.2 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_en | input | 1 | 1 runs a measurement; 0 clears and holds the block |
| sel_hi | input | 1 | 1 selects the prescaled high-band input |
| freq_sel | input | 1 | Low-band input only: 1 selects frequency mode, 0 selects period mode |
| long_gate | input | 1 | 0 selects the short window or one period; 1 selects the long window or two periods |
| hi_in | input | 1 | High-band measured signal (asynchronous) |
| lo_in | input | 1 | Low-band measured signal (asynchronous) |
| count_o | output | CNT_W | Measurement result |
| done_o | output | 1 | Measurement complete |

## Verification
The bench builds the block with CNT_W=8, GATE_SHORT=200, GATE_LONG=400 and CHK_DIV=4, and keeps HB_DIV at 8. These short windows allow a sweep over every edge count from 0 to 40 on both bands, and place the exact cycle on which `done_o` rises within easy reach. The 8-bit counter can be driven past all ones by a long two-period measurement, which exercises saturation. Several period lengths that are not multiples of the check divisor exercise the floor in the period result.

// File: rtl/mc_pkg.sv
package mc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATE,
        ST_ARM,
        ST_SPAN,
        ST_DONE
    } mc_state_e;
endpackage

// File: rtl/mc_edge_sync.sv
module mc_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [2:0] sq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq <= '0;
        else        sq <= {sq[1:0], din};
    end

    assign rise = sq[1] & ~sq[2];
endmodule

// File: rtl/mc_prescale.sv
module mc_prescale #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic rise_in,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = rise_in & ~clr;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            logic [PW-1:0] pcnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       pcnt <= '0;
                else if (clr)     pcnt <= '0;
                else if (rise_in) pcnt <= (pcnt == PW'(DIV-1)) ? '0 : pcnt + 1'b1;
            end

            assign tick = ~clr & rise_in & (pcnt == PW'(DIV-1));

            // R2: prescaler phase stays inside its modulus
            p_presc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
                pcnt <= PW'(DIV-1));
        end
    endgenerate
endmodule

// File: rtl/mc_window.sv
module mc_window #(
    parameter int GATE_SHORT = 432000,
    parameter int GATE_LONG  = 864000,
    parameter int CHK_DIV    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_run,
    input  logic span_run,
    input  logic long_sel,
    output logic gate_end,
    output logic chk_tick
);
    localparam int GW = $clog2(GATE_LONG + 1);

    logic [GW-1:0] gate_cnt;
    logic [GW-1:0] gate_lim;

    assign gate_lim = long_sel ? GW'(GATE_LONG - 1) : GW'(GATE_SHORT - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        gate_cnt <= '0;
        else if (!gate_run) gate_cnt <= '0;
        else               gate_cnt <= gate_cnt + 1'b1;
    end

    assign gate_end = gate_run & (gate_cnt == gate_lim);

    // R4: the window counter never runs past the long limit
    p_gate_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gate_run |-> (gate_cnt <= GW'(GATE_LONG - 1)));

    generate
        if (CHK_DIV <= 1) begin : g_nodiv
            assign chk_tick = span_run;
        end else begin : g_div
            localparam int DW = $clog2(CHK_DIV);
            logic [DW-1:0] dcnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        dcnt <= '0;
                else if (!span_run) dcnt <= '0;
                else               dcnt <= (dcnt == DW'(CHK_DIV-1)) ? '0 : dcnt + 1'b1;
            end

            assign chk_tick = span_run & (dcnt == DW'(CHK_DIV-1));
        end
    endgenerate
endmodule

// File: rtl/meas_counter.sv
module meas_counter
    import mc_pkg::*;
#(
    parameter int CNT_W      = 20,
    parameter int GATE_SHORT = 432000,
    parameter int GATE_LONG  = 864000,
    parameter int CHK_DIV    = 8,
    parameter int HB_DIV     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_en,
    input  logic             sel_hi,
    input  logic             freq_sel,
    input  logic             long_gate,
    input  logic             hi_in,
    input  logic             lo_in,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    mc_state_e        state, nxt;
    logic             cfg_hi, cfg_freq, cfg_long;
    logic [1:0]       per_left;
    logic [CNT_W-1:0] cnt_q;
    logic             src, rise, hb_tick, gate_end, chk_tick;
    logic             step;

    // Configuration is captured while idle only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_hi   <= 1'b0;
            cfg_freq <= 1'b0;
            cfg_long <= 1'b0;
        end else if (state == ST_IDLE) begin
            cfg_hi   <= sel_hi;
            cfg_freq <= freq_sel;
            cfg_long <= long_gate;
        end
    end

    // Disabled block sees both inputs as held low
    assign src = meas_en & (cfg_hi ? hi_in : lo_in);

    mc_edge_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (src),
        .rise  (rise)
    );

    mc_prescale #(.DIV(HB_DIV)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state != ST_GATE),
        .rise_in (rise),
        .tick    (hb_tick)
    );

    mc_window #(
        .GATE_SHORT (GATE_SHORT),
        .GATE_LONG  (GATE_LONG),
        .CHK_DIV    (CHK_DIV)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_run (state == ST_GATE),
        .span_run (state == ST_SPAN),
        .long_sel (cfg_long),
        .gate_end (gate_end),
        .chk_tick (chk_tick)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (meas_en) nxt = (sel_hi || freq_sel) ? ST_GATE : ST_ARM;
            ST_GATE: if (gate_end) nxt = ST_DONE;
            ST_ARM:  if (rise) nxt = ST_SPAN;
            ST_SPAN: if (rise && per_left == 2'd1) nxt = ST_DONE;
            ST_DONE: nxt = ST_DONE;
            default: nxt = ST_IDLE;
        endcase
        if (!meas_en) nxt = ST_IDLE;
    end

    // Remaining periods in period mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     per_left <= 2'd1;
        else if (state == ST_IDLE)      per_left <= long_gate ? 2'd2 : 2'd1;
        else if (state == ST_SPAN && rise) per_left <= per_left - 2'd1;
    end

    // Saturating result counter
    assign step = ((state == ST_GATE) && (cfg_hi ? hb_tick : rise))
                | ((state == ST_SPAN) && chk_tick);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (!meas_en)                  cnt_q <= '0;
        else if (step && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
    end

    // Outputs
    always_comb begin
        count_o = cnt_q;
        done_o  = (state == ST_DONE);
    end

    p_clear_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_en |=> (count_o == '0 && !done_o));

    p_hold_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && meas_en) |=> (done_o && $stable(count_o)));

    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_en && count_o == CNT_MAX) |=> (count_o == CNT_MAX));

    p_gate_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_end && meas_en) |=> done_o);

    p_no_run_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !done_o);
endmodule

// File: tb/meas_counter_tb.sv
module meas_counter_tb_top;
    localparam int CW  = 8;
    localparam int GS  = 200;
    localparam int GL  = 400;
    localparam int CD  = 4;
    localparam int HB  = 8;
    localparam int MAXV = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, sc = 1'b0, sf = 1'b0, gt = 1'b0, hi = 1'b0, lo = 1'b0;
    logic [CW-1:0] cnt;
    logic done;
    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    meas_counter #(
        .CNT_W(CW), .GATE_SHORT(GS), .GATE_LONG(GL), .CHK_DIV(CD), .HB_DIV(HB)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .meas_en(en), .sel_hi(sc), .freq_sel(sf),
        .long_gate(gt), .hi_in(hi), .lo_in(lo), .count_o(cnt), .done_o(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic pulse(input logic use_hi);
        @(negedge clk); if (use_hi) hi = 1'b1; else lo = 1'b1;
        @(negedge clk);
        @(negedge clk); hi = 1'b0; lo = 1'b0;
        @(negedge clk);
    endtask

    task automatic stop_run();
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        chk("R1 count cleared", int'(cnt), 0);
        chk("R1 done cleared", int'(done), 0);
    endtask

    task automatic run_freq(input logic s_hi, input logic s_f, input logic g, input int n);
        int e0c, lim, exp;
        lim = g ? GL : GS;
        @(negedge clk); sc = s_hi; sf = s_f; gt = g; en = 1'b1;
        @(negedge clk); e0c = cyc;
        for (int i = 0; i < n; i++) pulse(s_hi);
        // R8: flip configuration mid-run
        sc = ~s_hi; sf = ~s_f; gt = ~g;
        while (cyc < e0c + lim - 1) @(negedge clk);
        chk("R4 done low before window end", int'(done), 0);
        @(negedge clk);
        chk("R4 done at window end", int'(done), 1);
        exp = s_hi ? n / HB : n;
        chk(s_hi ? "R2 high-band count" : "R3 low-band count", int'(cnt), exp);
        pulse(s_hi); pulse(s_hi);
        chk("R6 count held after done", int'(cnt), exp);
        chk("R6 done held", int'(done), 1);
        stop_run();
    endtask

    task automatic run_per(input logic g, input int p);
        int k, exp;
        k = g ? 2 : 1;
        @(negedge clk); sc = 1'b0; sf = 1'b0; gt = g; en = 1'b1;
        repeat (3) @(negedge clk);
        for (int r = 0; r <= k; r++) begin
            if (r == 1) begin sc = 1'b1; sf = 1'b1; gt = ~g; end  // R8
            if (r == k) chk("R6 done low mid-period", int'(done), 0);
            lo = 1'b1;
            repeat (p / 2) @(negedge clk);
            lo = 1'b0;
            repeat (p - p / 2) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        exp = (k * p) / CD;
        if (exp > MAXV) exp = MAXV;
        chk("R6 done after periods", int'(done), 1);
        chk(exp == MAXV ? "R7 saturated count" : "R5 period count", int'(cnt), exp);
        stop_run();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset count", int'(cnt), 0);
        chk("R1 reset done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: edges while disabled are ignored
        for (int i = 0; i < 10; i++) pulse(1'b0);
        chk("R1 disabled count", int'(cnt), 0);
        chk("R1 disabled done", int'(done), 0);
        run_freq(1'b0, 1'b1, 1'b0, 0);
        for (int n = 0; n <= 40; n++) run_freq(1'b0, 1'b1, 1'b0, n);
        for (int n = 0; n <= 40; n++) run_freq(1'b1, n[0], 1'b0, n);
        run_freq(1'b0, 1'b1, 1'b1, 50);
        run_freq(1'b0, 1'b1, 1'b1, 90);
        run_freq(1'b1, 1'b0, 1'b1, 90);
        for (int p = 16; p <= 40; p += 3) begin
            run_per(1'b0, p);
            run_per(1'b1, p);
        end
        run_per(1'b1, 600);
        run_per(1'b0, 1100);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule